// File: doc/BRIEF.md
# Lock Elision Entry Buffer

This block keeps a small table of the locks that one hardware thread is currently eliding. When the core sees a lock-acquire store that carries an elision hint, it presents the lock address, the lock value it read, and the value the store would write. If the lock looks free and a slot is open, the block grants elision. It then records the 64-byte line of the lock, the original value and the would-be value, and the store is not performed. A later hinted release store to the same line must write back the original value. When it does, the slot is freed. When it does not, the transaction is aborted.

A full table never aborts. The acquire is simply granted as a real locked write. Any abort, whether raised inside the block or strobed in from outside, empties the table and sets a no-elide flag. While that flag is set, every hinted acquire is performed for real. The next hinted release marks the end of that non-elided section and clears the flag. A commit strobe empties the table without touching the flag. Loads probe the table so that a read of an elided lock returns the would-be value.

Top module: `lock_elide_tbl`

## Requirements
- R1: After reset no slot is valid and the no-elide flag is clear. Every grant output and `abort_req` are 0, and `rd_hit` is 0 for any address.
- R2: An acquire (`acq_vld`=1) that meets all of the following gets `acq_elide`=1. The flag is clear, `acq_old` equals the free value 0, no valid slot holds the same line, and a slot is open. The address bits above bit 5 (the 64-byte line), `acq_old` and `acq_new` are stored, and the count of valid slots grows by one.
- R3: When every slot is valid, an otherwise elidable acquire gets `acq_real`=1 and `abort_req`=0, and the slots are left unchanged.
- R4: With the flag clear, an acquire is aborted (`abort_req`=1, no grant) in either of two cases: `acq_old` is not 0, or its line is already held by a valid slot.
- R5: `rd_hit` is 1 exactly when `rd_addr` falls in the line of a valid slot. In that case `rd_data` is that slot's would-be value.
- R6: A release (`rel_vld`=1) that meets all of the following gets `rel_elide`=1 and frees that slot. The flag is clear, the release hits a valid slot's line, and `rel_data` equals that slot's original value. A hit with any other data raises `abort_req` instead.
- R7: With the flag clear, a release whose line matches no valid slot gets `rel_real`=1 and does not abort.
- R8: In a cycle where `abort_req` is 1, whether from R4, from R6 or from `abt_i`, all slots are invalid from the next cycle on and `noelide_o` becomes 1.
- R9: While `noelide_o` is 1, every acquire gets `acq_real`=1 without abort. A release gets `rel_real`=1 and clears the flag.
- R10: `cmt_i` invalidates every slot by the next cycle and leaves the flag unchanged.
- R11: When `acq_vld` and `rel_vld` are high together, the release is ignored: no release grant, and the slots are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_vld | input | 1 | Hinted acquire request |
| acq_addr | input | PA_W | Physical address of the lock |
| acq_old | input | DATA_W | Lock value observed by the acquire |
| acq_new | input | DATA_W | Value the acquire would store |
| rel_vld | input | 1 | Hinted release request |
| rel_addr | input | PA_W | Physical address of the release store |
| rel_data | input | DATA_W | Data of the release store |
| rd_addr | input | PA_W | Load address probed against the table |
| cmt_i | input | 1 | Transaction commit strobe |
| abt_i | input | 1 | External abort strobe |
| acq_elide | output | 1 | Acquire elided, slot allocated |
| acq_real | output | 1 | Acquire must be performed as a real locked write |
| rel_elide | output | 1 | Release matched and its slot freed |
| rel_real | output | 1 | Release must be performed as a real store |
| abort_req | output | 1 | Transaction must abort |
| rd_hit | output | 1 | Load address lies in an elided lock line |
| rd_data | output | DATA_W | Would-be lock value forwarded to the load |
| noelide_o | output | 1 | Elision disabled until the next release |

## Verification
The bench fills every slot and then offers one more acquire. A design that aborted there, or that overwrote a slot, would break the fallback rule. It also releases with wrong data, re-acquires a held line at a different byte offset, and probes reads at offsets other than the one stored. These catch a design that compared full addresses instead of lines, or that freed a slot without checking the data. Aborts during the no-elide window and commits with the flag set separate a flag that clears on commit from one that clears on release. A long mixed sweep over six lines with four slots drives the table through full, partially full and empty states, and checks each grant against a model computed from the rules.

// File: rtl/lock_elide_pkg.sv
package lock_elide_pkg;
   typedef enum logic [1:0] {
      ACQ_NONE,
      ACQ_ELIDE,
      ACQ_REAL,
      ACQ_ABORT
   } acq_res_e;

   typedef enum logic [1:0] {
      REL_NONE,
      REL_ELIDE,
      REL_REAL,
      REL_ABORT
   } rel_res_e;
endpackage

// File: rtl/lock_elide_slot.sv
module lock_elide_slot #(
   parameter int TAG_W  = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              alloc_i,
   input  logic              free_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] new_i,
   output logic              vld_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] old_o,
   output logic [DATA_W-1:0] new_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         tag_o <= '0;
         old_o <= '0;
         new_o <= '0;
      end else if (clr_i) begin
         vld_o <= 1'b0;
      end else if (alloc_i) begin
         vld_o <= 1'b1;
         tag_o <= tag_i;
         old_o <= old_i;
         new_o <= new_i;
      end else if (free_i) begin
         vld_o <= 1'b0;
      end
   end
endmodule

// File: rtl/lock_elide_pick.sv
module lock_elide_pick #(
   parameter int N_ENT = 4
) (
   input  logic [N_ENT-1:0] free_i,
   output logic [N_ENT-1:0] gnt_o,
   output logic             any_o
);
   always_comb begin
      gnt_o = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (free_i[i]) begin
            gnt_o = '0;
            gnt_o[i] = 1'b1;
         end
      end
      any_o = |free_i;
   end
endmodule

// File: rtl/lock_elide_cam.sv
module lock_elide_cam #(
   parameter int N_ENT  = 4,
   parameter int TAG_W  = 10,
   parameter int DATA_W = 8
) (
   input  logic [TAG_W-1:0]             key_i,
   input  logic [N_ENT-1:0]             vld_i,
   input  logic [N_ENT-1:0][TAG_W-1:0]  tag_i,
   input  logic [N_ENT-1:0][DATA_W-1:0] dat_i,
   output logic [N_ENT-1:0]             hit_vec_o,
   output logic                         hit_o,
   output logic [DATA_W-1:0]            dat_o
);
   genvar g;
   generate
      for (g = 0; g < N_ENT; g++) begin : g_cmp
         assign hit_vec_o[g] = vld_i[g] && (tag_i[g] == key_i);
      end
   endgenerate

   always_comb begin
      dat_o = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (hit_vec_o[i]) dat_o = dat_o | dat_i[i];
      end
      hit_o = |hit_vec_o;
   end
endmodule

// File: rtl/lock_elide_tbl.sv
module lock_elide_tbl #(
   parameter int              N_ENT     = 4,
   parameter int              PA_W      = 16,
   parameter int              DATA_W    = 8,
   parameter int              LINE_BITS = 6,
   parameter logic [DATA_W-1:0] FREE_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_vld,
   input  logic [PA_W-1:0]   acq_addr,
   input  logic [DATA_W-1:0] acq_old,
   input  logic [DATA_W-1:0] acq_new,
   input  logic              rel_vld,
   input  logic [PA_W-1:0]   rel_addr,
   input  logic [DATA_W-1:0] rel_data,
   input  logic [PA_W-1:0]   rd_addr,
   input  logic              cmt_i,
   input  logic              abt_i,
   output logic              acq_elide,
   output logic              acq_real,
   output logic              rel_elide,
   output logic              rel_real,
   output logic              abort_req,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_data,
   output logic              noelide_o
);
   import lock_elide_pkg::*;

   localparam int TAG_W = PA_W - LINE_BITS;

   initial begin
      assert (N_ENT >= 1) else $error("N_ENT must be at least 1");
      assert (LINE_BITS < PA_W) else $error("LINE_BITS must be below PA_W");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic [N_ENT-1:0]             vld;
   logic [N_ENT-1:0][TAG_W-1:0]  tags;
   logic [N_ENT-1:0][DATA_W-1:0] olds;
   logic [N_ENT-1:0][DATA_W-1:0] news;

   logic [TAG_W-1:0] acq_tag, rel_tag, rd_tag;
   assign acq_tag = acq_addr[PA_W-1:LINE_BITS];
   assign rel_tag = rel_addr[PA_W-1:LINE_BITS];
   assign rd_tag  = rd_addr[PA_W-1:LINE_BITS];

   logic [N_ENT-1:0]  acq_hvec, rel_hvec, rd_hvec;
   logic              acq_hit, rel_hit;
   logic [DATA_W-1:0] acq_unused, rel_old;

   lock_elide_cam #(.N_ENT(N_ENT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cam_acq (
      .key_i(acq_tag), .vld_i(vld), .tag_i(tags), .dat_i(news),
      .hit_vec_o(acq_hvec), .hit_o(acq_hit), .dat_o(acq_unused));

   lock_elide_cam #(.N_ENT(N_ENT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cam_rel (
      .key_i(rel_tag), .vld_i(vld), .tag_i(tags), .dat_i(olds),
      .hit_vec_o(rel_hvec), .hit_o(rel_hit), .dat_o(rel_old));

   lock_elide_cam #(.N_ENT(N_ENT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cam_rd (
      .key_i(rd_tag), .vld_i(vld), .tag_i(tags), .dat_i(news),
      .hit_vec_o(rd_hvec), .hit_o(rd_hit), .dat_o(rd_data));

   logic [N_ENT-1:0] alloc_oh;
   logic             any_free;

   lock_elide_pick #(.N_ENT(N_ENT)) u_pick (
      .free_i(~vld), .gnt_o(alloc_oh), .any_o(any_free));

   logic     noelide_q;
   acq_res_e acq_res;
   rel_res_e rel_res;

   always_comb begin
      acq_res = ACQ_NONE;
      if (acq_vld) begin
         if (noelide_q)                          acq_res = ACQ_REAL;
         else if (acq_old != FREE_VAL || acq_hit) acq_res = ACQ_ABORT;
         else if (any_free)                       acq_res = ACQ_ELIDE;
         else                                     acq_res = ACQ_REAL;
      end
   end

   always_comb begin
      rel_res = REL_NONE;
      if (rel_vld && !acq_vld) begin
         if (noelide_q)                     rel_res = REL_REAL;
         else if (rel_hit && rel_data == rel_old) rel_res = REL_ELIDE;
         else if (rel_hit)                  rel_res = REL_ABORT;
         else                               rel_res = REL_REAL;
      end
   end

   assign acq_elide = (acq_res == ACQ_ELIDE);
   assign acq_real  = (acq_res == ACQ_REAL);
   assign rel_elide = (rel_res == REL_ELIDE);
   assign rel_real  = (rel_res == REL_REAL);
   assign abort_req = abt_i || (acq_res == ACQ_ABORT) || (rel_res == REL_ABORT);

   logic clr_all;
   assign clr_all = cmt_i || abort_req;

   genvar g;
   generate
      for (g = 0; g < N_ENT; g++) begin : g_slot
         lock_elide_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clr_i(clr_all),
            .alloc_i(acq_elide && alloc_oh[g]),
            .free_i(rel_elide && rel_hvec[g]),
            .tag_i(acq_tag), .old_i(acq_old), .new_i(acq_new),
            .vld_o(vld[g]), .tag_o(tags[g]), .old_o(olds[g]), .new_o(news[g]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                           noelide_q <= 1'b0;
      else if (abort_req)                   noelide_q <= 1'b1;
      else if (noelide_q && rel_real)       noelide_q <= 1'b0;
   end

   assign noelide_o = noelide_q;
endmodule

// File: rtl/lock_elide_chk.sv
module lock_elide_chk #(
   parameter int N_ENT  = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] FREE_VAL = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acq_vld,
   input logic [DATA_W-1:0] acq_old,
   input logic              cmt_i,
   input logic              acq_elide,
   input logic              acq_real,
   input logic              rel_elide,
   input logic              rel_real,
   input logic              abort_req,
   input logic              noelide_o,
   input logic              acq_hit,
   input logic [N_ENT-1:0]  vld
);
   a_r3_full_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_vld && !noelide_o && (&vld) && acq_old == FREE_VAL && !acq_hit)
      |-> (acq_real && !acq_elide));

   a_r8_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> (vld == '0 && noelide_o));

   a_r10_commit_empties: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_i |=> (vld == '0));

   a_r9_noelide_real: assert property (@(posedge clk) disable iff (!rst_n)
      (noelide_o && acq_vld) |-> (acq_real && !acq_elide));

   a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_elide && !abort_req && !cmt_i)
      |=> ($countones(vld) == $past($countones(vld)) + 1));

   a_r6_free_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_elide && !abort_req && !cmt_i)
      |=> ($countones(vld) + 1 == $past($countones(vld))));

   a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acq_elide, acq_real, rel_elide, rel_real}));
endmodule

bind lock_elide_tbl lock_elide_chk #(.N_ENT(N_ENT), .DATA_W(DATA_W), .FREE_VAL(FREE_VAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .acq_vld(acq_vld), .acq_old(acq_old), .cmt_i(cmt_i),
   .acq_elide(acq_elide), .acq_real(acq_real), .rel_elide(rel_elide),
   .rel_real(rel_real), .abort_req(abort_req), .noelide_o(noelide_o),
   .acq_hit(acq_hit), .vld(vld));

// File: tb/lock_elide_tbl_bench.sv
module lock_elide_tbl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        acq_vld = 0, rel_vld = 0, cmt_i = 0, abt_i = 0;
   logic [15:0] acq_addr = 0, rel_addr = 0, rd_addr = 0;
   logic [7:0]  acq_old = 0, acq_new = 0, rel_data = 0;
   logic        acq_elide, acq_real, rel_elide, rel_real, abort_req, rd_hit, noelide_o;
   logic [7:0]  rd_data;

   lock_elide_tbl u_lock_elide_tbl (
      .clk(clk), .rst_n(rst_n), .acq_vld(acq_vld), .acq_addr(acq_addr),
      .acq_old(acq_old), .acq_new(acq_new), .rel_vld(rel_vld), .rel_addr(rel_addr),
      .rel_data(rel_data), .rd_addr(rd_addr), .cmt_i(cmt_i), .abt_i(abt_i),
      .acq_elide(acq_elide), .acq_real(acq_real), .rel_elide(rel_elide),
      .rel_real(rel_real), .abort_req(abort_req), .rd_hit(rd_hit),
      .rd_data(rd_data), .noelide_o(noelide_o));

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   bit         mv[4];
   logic [9:0] mtag[4];
   logic [7:0] mold[4], mnew[4];
   bit         mflag;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic clr_model();
      for (int i = 0; i < 4; i++) mv[i] = 0;
   endtask

   function automatic int find(logic [15:0] a);
      for (int i = 0; i < 4; i++) if (mv[i] && mtag[i] == a[15:6]) return i;
      return -1;
   endfunction

   task automatic idle();
      acq_vld = 0; rel_vld = 0; cmt_i = 0; abt_i = 0;
   endtask

   task automatic do_acq(logic [15:0] a, logic [7:0] o, logic [7:0] n,
                         bit with_rel = 0, logic [15:0] ra = 0, logic [7:0] rdat = 0);
      bit ee = 0, er = 0, ea = 0;
      int fr = -1;
      string req;
      @(negedge clk);
      acq_vld = 1; acq_addr = a; acq_old = o; acq_new = n;
      rel_vld = with_rel; rel_addr = ra; rel_data = rdat;
      #2;
      for (int i = 3; i >= 0; i--) if (!mv[i]) fr = i;
      if (mflag)                       begin er = 1; req = "R9 acquire under no-elide"; end
      else if (o != 0 || find(a) >= 0) begin ea = 1; req = "R4 acquire abort"; end
      else if (fr >= 0)                begin ee = 1; req = "R2 acquire elide"; end
      else                             begin er = 1; req = "R3 full fallback"; end
      chk(req, {acq_elide, acq_real, abort_req}, {ee, er, ea});
      if (with_rel) chk("R11 release ignored", {rel_elide, rel_real}, 2'b00);
      @(posedge clk); #1;
      idle();
      if (ea) begin clr_model(); mflag = 1; end
      if (ee) begin mv[fr] = 1; mtag[fr] = a[15:6]; mold[fr] = o; mnew[fr] = n; end
   endtask

   task automatic do_rel(logic [15:0] a, logic [7:0] d);
      bit re = 0, rr = 0, ea = 0, cf = 0;
      int h;
      string req;
      @(negedge clk);
      rel_vld = 1; rel_addr = a; rel_data = d;
      #2;
      h = find(a);
      if (mflag)                        begin rr = 1; cf = 1; req = "R9 release ends no-elide"; end
      else if (h >= 0 && d == mold[h])  begin re = 1; req = "R6 release match"; end
      else if (h >= 0)                  begin ea = 1; req = "R6 release data mismatch"; end
      else                              begin rr = 1; req = "R7 unmatched release"; end
      chk(req, {rel_elide, rel_real, abort_req}, {re, rr, ea});
      @(posedge clk); #1;
      idle();
      if (cf) mflag = 0;
      if (re) mv[h] = 0;
      if (ea) begin clr_model(); mflag = 1; end
   endtask

   task automatic do_cmt();
      @(negedge clk);
      cmt_i = 1; #2;
      chk("R10 commit no abort", abort_req, 0);
      @(posedge clk); #1;
      idle(); clr_model();
   endtask

   task automatic do_abt();
      @(negedge clk);
      abt_i = 1; #2;
      chk("R8 external abort", abort_req, 1);
      @(posedge clk); #1;
      idle(); clr_model(); mflag = 1;
   endtask

   task automatic do_rd(logic [15:0] a);
      int h;
      @(negedge clk);
      rd_addr = a; #2;
      h = find(a);
      chk("R5 read hit", rd_hit, h >= 0);
      if (h >= 0) chk("R5 read forward", rd_data, mnew[h]);
      chk("R8 R9 flag state", noelide_o, mflag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      clr_model(); mflag = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      @(negedge clk); #2;
      chk("R1 reset grants", {acq_elide, acq_real, rel_elide, rel_real, abort_req}, 0);
      chk("R1 reset flag", noelide_o, 0);
      for (int k = 0; k < 8; k++) do_rd(16'(k * 64 + k));

      // R2 fill every slot, R3 fallback when full
      for (int i = 0; i < 4; i++) do_acq(16'(i * 64 + i), 8'h00, 8'(i + 1));
      do_acq(16'h0400, 8'h00, 8'h77);
      for (int i = 0; i < 5; i++) do_rd(16'(i * 64 + 63 - i));

      // R11 simultaneous release ignored, then R6 correct release
      do_rel(16'h0041, 8'h00);
      do_acq(16'h0500, 8'h00, 8'h09, 1, 16'h0000, 8'h00);
      do_rd(16'h0000);
      // R6 wrong release data aborts, R8 empties
      do_rel(16'h0080, 8'h3c);
      for (int i = 0; i < 4; i++) do_rd(16'(i * 64));
      // R9 no-elide window survives commit, ends on release
      do_acq(16'h0100, 8'h00, 8'h01);
      do_cmt();
      do_rd(16'h0100);
      do_rel(16'h0100, 8'h00);
      do_rd(16'h0100);
      // R4 re-acquire held line at other offset, and busy lock
      do_acq(16'h0200, 8'h00, 8'h05);
      do_acq(16'h0217, 8'h00, 8'h06);
      do_rel(16'h0200, 8'h00);
      do_acq(16'h0300, 8'h01, 8'h02);
      do_rel(16'h0300, 8'h00);
      // R7 unmatched release, R10 commit, R8 external abort
      do_acq(16'h0240, 8'h00, 8'h0a);
      do_rel(16'h0800, 8'h11);
      do_rd(16'h0240);
      do_cmt();
      do_rd(16'h0240);
      do_acq(16'h0280, 8'h00, 8'h0b);
      do_abt();
      do_rd(16'h0280);
      do_rel(16'h0280, 8'h00);

      // mixed sweep over six lines and four slots
      for (int k = 0; k < 240; k++) begin
         logic [15:0] a = 16'(((k * 5) % 6) * 64 + (k % 64));
         case ((k * 7 + 3) % 6)
            0, 1: do_acq(a, (k % 11 == 0) ? 8'h01 : 8'h00, 8'(k));
            2:    do_rel(a, (k % 4 == 0) ? 8'h55 : 8'h00);
            3:    do_rd(a);
            4:    if (k % 5 == 0) do_cmt(); else do_rd(a);
            default: if (k % 13 == 0) do_abt(); else do_acq(a, 8'h00, 8'(k + 3));
         endcase
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule